// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Slave

This block is the device side of a one-wire, open-drain, command-driven link to a host controller. The host opens a conversation with a long low pulse (a break), then clocks an eight-bit command across the wire, least-significant bit first. Bit 7 of the command chooses direction (1 = host writes, 0 = host reads) and bits 6:0 carry a register address. A write is followed by one data byte from the host. A read is answered by the slave, which shifts out the selected register byte on the same wire.

Every bit is a return-to-one frame. A falling edge opens the frame, the level held in the middle of the frame is the bit value, and the wire is high again before the frame closes. The slave never drives the wire high. It only asserts a pull-down request. All timing is counted in ticks of an internal timebase, which divides the clock by `PRESCALE`.

Behind the link sits a small register file. Flags, temperature/gauge and the low charge byte come in as live inputs. The high charge byte, identification byte, learned-capacity byte and output-control byte are stored locally and brought out on ports. A keyed two-write sequence triggers a full reset.

Top module: `swr_slave`

## Requirements
- R1: After `rst_n` is released, `line_pull_o` and `full_rst_o` are 0, `chg_hi_o`, `ident_o` and `outctl_o` are 0x00, and `learn_o` equals `LEARN_INIT`.
- R2: A break is the wire held low for `T_BREAK` ticks. Until the first break after reset, no frame on the wire is accepted as a command.
- R3: The receiver samples each bit `T_SAMPLE` ticks after its falling edge (low = 0) and assembles bytes LSB first. Command bit 7 = 1 selects write and 0 selects read. Bits 6:0 are the address.
- R4: Writing address 0x03 updates `chg_hi_o`, 0x04 updates `ident_o`, 0x05 updates `learn_o` and 0x0A updates `outctl_o`. Each update is visible once the data byte's last frame has returned high.
- R5: A write to any address other than 0x03, 0x04, 0x05, 0x0A or 0x39 changes none of the stored registers.
- R6: A read returns `flags_i` for 0x01, `tempgg_i` for 0x02, the stored high charge byte for 0x03, `chg_lo_i` for 0x17, the identification byte for 0x04 and the learned capacity for 0x05. Every other address returns 0x00.
- R7: The reply starts `T_TURN` ticks after the command's last frame returns high and is sent LSB first. Each bit lasts `T_TX_BIT` ticks. A 1 pulls low for `T_TX_LOW` ticks and a 0 pulls low for `T_TX_HOLD` ticks. There is no pull at any other time.
- R8: Writing 0x00 to 0x05 and then, as the very next write, 0x80 to 0x39 gives a one-cycle `full_rst_o` pulse. It sets `learn_o` to `LEARN_INIT` and clears `chg_hi_o` and `outctl_o`, while `ident_o` keeps its value.
- R9: A write to 0x39 without the immediately preceding 0x00-to-0x05 write, or with a value other than 0x80, produces no pulse and changes no register.
- R10: A break at any point aborts the transfer in progress. A write whose final data frame is stretched into a break does not commit. After the break the slave accepts a new command without needing another break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sensed level of the shared wire |
| line_pull_o | output | 1 | 1 = pull the wire low |
| flags_i | input | 8 | Live status flags, read at 0x01 |
| tempgg_i | input | 8 | Live temperature/gauge byte, read at 0x02 |
| chg_lo_i | input | 8 | Live low charge byte, read at 0x17 |
| chg_hi_o | output | 8 | Stored high charge byte |
| ident_o | output | 8 | Stored identification byte |
| learn_o | output | 8 | Stored learned-capacity byte |
| outctl_o | output | 8 | Stored output-control byte |
| full_rst_o | output | 1 | One-cycle full-reset pulse |

## Verification
The delicate overlap is between break detection and the commit of a write's final data byte. Both are driven by the same low stretch of wire in the last frame. The bench provokes this by holding the last data bit of a write low past the break length. It judges the outcome at the ports: `ident_o` must keep its old value, and a following write sent without a new break must land. A second overlap, the reset-register write arriving in the same cycle as the full reset it fires, is judged from the pulse count and from all four stored bytes read on the ports immediately afterwards.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [2:0] {
        E_IDLE,
        E_BRK_HI,
        E_RX_FALL,
        E_RX_SAMPLE,
        E_RX_HI,
        E_TX_TURN,
        E_TX_BIT
    } eng_state_e;

    localparam logic [6:0] A_FLAGS  = 7'h01;
    localparam logic [6:0] A_TEMPGG = 7'h02;
    localparam logic [6:0] A_CHG_HI = 7'h03;
    localparam logic [6:0] A_IDENT  = 7'h04;
    localparam logic [6:0] A_LEARN  = 7'h05;
    localparam logic [6:0] A_OUTCTL = 7'h0A;
    localparam logic [6:0] A_CHG_LO = 7'h17;
    localparam logic [6:0] A_RESET  = 7'h39;

    localparam logic [7:0] RESET_KEY = 8'h80;

    typedef struct packed {
        logic [7:0] chg_hi;
        logic [7:0] ident;
        logic [7:0] learn;
        logic [7:0] outctl;
        logic       armed;
        logic       full_rst;
    } regs_t;

endpackage

// File: rtl/swr_timebase.sv
module swr_timebase #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_d, div_q;

            always_comb begin
                div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/swr_linesense.sv
module swr_linesense #(
    parameter int T_BREAK = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic brk_o
);
    localparam int BW = $clog2(T_BREAK + 1);
    localparam logic [BW-1:0] SAT  = BW'(T_BREAK);
    localparam logic [BW-1:0] EDGE = BW'(T_BREAK - 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          prev;
        logic [BW-1:0] low_cnt;
        logic          brk;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], line_i};
        s_d.prev = s_q.sync[1];
        s_d.brk  = 1'b0;
        if (s_q.sync[1]) begin
            s_d.low_cnt = '0;
        end else if (tick_i && s_q.low_cnt != SAT) begin
            s_d.low_cnt = s_q.low_cnt + 1'b1;
            s_d.brk     = (s_q.low_cnt == EDGE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: 2'b11, prev: 1'b1, low_cnt: '0, brk: 1'b0};
        else        s_q <= s_d;
    end

    assign line_o = s_q.sync[1];
    assign fall_o = s_q.prev & ~s_q.sync[1];
    assign brk_o  = s_q.brk;

    AST_BRK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> $past(!line_o)); // R2
endmodule

// File: rtl/swr_engine.sv
module swr_engine
    import swr_pkg::*;
#(
    parameter int T_SAMPLE  = 110,
    parameter int T_TURN    = 100,
    parameter int T_TX_LOW  = 60,
    parameter int T_TX_HOLD = 200,
    parameter int T_TX_BIT  = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       line_i,
    input  logic       fall_i,
    input  logic       brk_i,
    input  logic [7:0] rd_data_i,
    output logic [6:0] rd_addr_o,
    output logic       wr_stb_o,
    output logic [6:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       pull_o
);
    localparam int CW = $clog2(T_TX_BIT + T_SAMPLE + T_TURN + 1);
    localparam logic [CW-1:0] L_SMP  = CW'(T_SAMPLE - 1);
    localparam logic [CW-1:0] L_TURN = CW'(T_TURN - 1);
    localparam logic [CW-1:0] L_BIT  = CW'(T_TX_BIT - 1);
    localparam logic [CW-1:0] L_LOW  = CW'(T_TX_LOW);
    localparam logic [CW-1:0] L_HOLD = CW'(T_TX_HOLD);

    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] cnt;
        logic [2:0]    idx;
        logic [7:0]    sh;
        logic [7:0]    cmd;
        logic          data_ph;
        logic          wr;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d    = e_q;
        e_d.wr = 1'b0;
        if (brk_i) begin
            e_d.st      = E_BRK_HI;
            e_d.idx     = '0;
            e_d.cnt     = '0;
            e_d.data_ph = 1'b0;
        end else begin
            case (e_q.st)
                E_IDLE: ;
                E_BRK_HI: begin
                    if (line_i) e_d.st = E_RX_FALL;
                end
                E_RX_FALL: begin
                    if (fall_i) begin
                        e_d.st  = E_RX_SAMPLE;
                        e_d.cnt = '0;
                    end
                end
                E_RX_SAMPLE: begin
                    if (tick_i) begin
                        if (e_q.cnt == L_SMP) begin
                            e_d.sh = {line_i, e_q.sh[7:1]};
                            e_d.st = E_RX_HI;
                        end else begin
                            e_d.cnt = e_q.cnt + 1'b1;
                        end
                    end
                end
                E_RX_HI: begin
                    if (line_i) begin
                        if (e_q.idx == 3'd7) begin
                            e_d.idx = '0;
                            if (!e_q.data_ph) begin
                                e_d.cmd = e_q.sh;
                                if (e_q.sh[7]) begin
                                    e_d.data_ph = 1'b1;
                                    e_d.st      = E_RX_FALL;
                                end else begin
                                    e_d.sh  = rd_data_i;
                                    e_d.cnt = '0;
                                    e_d.st  = E_TX_TURN;
                                end
                            end else begin
                                e_d.wr      = 1'b1;
                                e_d.data_ph = 1'b0;
                                e_d.st      = E_RX_FALL;
                            end
                        end else begin
                            e_d.idx = e_q.idx + 3'd1;
                            e_d.st  = E_RX_FALL;
                        end
                    end
                end
                E_TX_TURN: begin
                    if (tick_i) begin
                        if (e_q.cnt == L_TURN) begin
                            e_d.cnt = '0;
                            e_d.st  = E_TX_BIT;
                        end else begin
                            e_d.cnt = e_q.cnt + 1'b1;
                        end
                    end
                end
                E_TX_BIT: begin
                    if (tick_i) begin
                        if (e_q.cnt == L_BIT) begin
                            e_d.cnt = '0;
                            e_d.sh  = {1'b0, e_q.sh[7:1]};
                            if (e_q.idx == 3'd7) begin
                                e_d.idx = '0;
                                e_d.st  = E_RX_FALL;
                            end else begin
                                e_d.idx = e_q.idx + 3'd1;
                            end
                        end else begin
                            e_d.cnt = e_q.cnt + 1'b1;
                        end
                    end
                end
                default: e_d.st = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: E_IDLE, cnt: '0, idx: '0, sh: '0, cmd: '0,
                             data_ph: 1'b0, wr: 1'b0};
        else        e_q <= e_d;
    end

    assign rd_addr_o = e_q.sh[6:0];
    assign wr_stb_o  = e_q.wr;
    assign wr_addr_o = e_q.cmd[6:0];
    assign wr_data_o = e_q.sh;
    assign pull_o    = (e_q.st == E_TX_BIT) &&
                       ((e_q.cnt < L_LOW) || (!e_q.sh[0] && e_q.cnt < L_HOLD));

    AST_BREAK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |=> (e_q.st == E_BRK_HI && !wr_stb_o)); // R10
    AST_WRITE_NEEDS_WCMD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> e_q.cmd[7]); // R3
endmodule

// File: rtl/swr_regbank.sv
module swr_regbank
    import swr_pkg::*;
#(
    parameter logic [7:0] LEARN_INIT = 8'h8C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb_i,
    input  logic [6:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [6:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    input  logic [7:0] flags_i,
    input  logic [7:0] tempgg_i,
    input  logic [7:0] chg_lo_i,
    output logic [7:0] chg_hi_o,
    output logic [7:0] ident_o,
    output logic [7:0] learn_o,
    output logic [7:0] outctl_o,
    output logic       full_rst_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.full_rst = 1'b0;
        if (wr_stb_i) begin
            r_d.armed = 1'b0;
            case (wr_addr_i)
                A_CHG_HI: r_d.chg_hi = wr_data_i;
                A_IDENT:  r_d.ident  = wr_data_i;
                A_OUTCTL: r_d.outctl = wr_data_i;
                A_LEARN: begin
                    r_d.learn = wr_data_i;
                    r_d.armed = (wr_data_i == 8'h00);
                end
                A_RESET: begin
                    if (r_q.armed && wr_data_i == RESET_KEY) begin
                        r_d.full_rst = 1'b1;
                        r_d.learn    = LEARN_INIT;
                        r_d.chg_hi   = 8'h00;
                        r_d.outctl   = 8'h00;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{chg_hi: 8'h00, ident: 8'h00, learn: LEARN_INIT,
                             outctl: 8'h00, armed: 1'b0, full_rst: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_addr_i)
            A_FLAGS:  rd_data_o = flags_i;
            A_TEMPGG: rd_data_o = tempgg_i;
            A_CHG_HI: rd_data_o = r_q.chg_hi;
            A_CHG_LO: rd_data_o = chg_lo_i;
            A_IDENT:  rd_data_o = r_q.ident;
            A_LEARN:  rd_data_o = r_q.learn;
            default:  rd_data_o = 8'h00;
        endcase
    end

    assign chg_hi_o   = r_q.chg_hi;
    assign ident_o    = r_q.ident;
    assign learn_o    = r_q.learn;
    assign outctl_o   = r_q.outctl;
    assign full_rst_o = r_q.full_rst;

    AST_FULL_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_o |=> !full_rst_o); // R8
    AST_KEY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_addr_i == A_RESET && !r_q.armed) |=> !full_rst_o); // R9
    AST_BAD_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_addr_i != A_CHG_HI && wr_addr_i != A_IDENT &&
         wr_addr_i != A_LEARN && wr_addr_i != A_OUTCTL && wr_addr_i != A_RESET)
        |=> $stable({chg_hi_o, ident_o, learn_o, outctl_o})); // R5
endmodule

// File: rtl/swr_slave.sv
module swr_slave
    import swr_pkg::*;
#(
    parameter int         PRESCALE   = 1,
    parameter int         T_BREAK    = 300,
    parameter int         T_SAMPLE   = 110,
    parameter int         T_TURN     = 100,
    parameter int         T_TX_LOW   = 60,
    parameter int         T_TX_HOLD  = 200,
    parameter int         T_TX_BIT   = 400,
    parameter logic [7:0] LEARN_INIT = 8'h8C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       line_pull_o,
    input  logic [7:0] flags_i,
    input  logic [7:0] tempgg_i,
    input  logic [7:0] chg_lo_i,
    output logic [7:0] chg_hi_o,
    output logic [7:0] ident_o,
    output logic [7:0] learn_o,
    output logic [7:0] outctl_o,
    output logic       full_rst_o
);
    logic       tick;
    logic       line_s, fall, brk;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic       wr_stb;

    swr_timebase #(.PRESCALE(PRESCALE)) i_tb (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    swr_linesense #(.T_BREAK(T_BREAK)) i_sense (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line_i),
        .line_o(line_s), .fall_o(fall), .brk_o(brk));

    swr_engine #(
        .T_SAMPLE(T_SAMPLE), .T_TURN(T_TURN), .T_TX_LOW(T_TX_LOW),
        .T_TX_HOLD(T_TX_HOLD), .T_TX_BIT(T_TX_BIT)
    ) i_eng (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line_s),
        .fall_i(fall), .brk_i(brk), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .pull_o(line_pull_o));

    swr_regbank #(.LEARN_INIT(LEARN_INIT)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .flags_i(flags_i), .tempgg_i(tempgg_i), .chg_lo_i(chg_lo_i),
        .chg_hi_o(chg_hi_o), .ident_o(ident_o), .learn_o(learn_o),
        .outctl_o(outctl_o), .full_rst_o(full_rst_o));
endmodule

// File: tb/test_swr_slave.sv
module test_swr_slave;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] LEARN_INIT = 8'h8C;
    localparam logic [7:0] FLAGS  = 8'hC9;
    localparam logic [7:0] TEMPGG = 8'h3E;
    localparam logic [7:0] CHG_LO = 8'h71;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_pull = 1'b0;
    logic line, line_pull_o, full_rst_o;
    logic [7:0] chg_hi_o, ident_o, learn_o, outctl_o;

    int vectors = 0;
    int miscompares = 0;
    int rx_seen = 0;
    int rst_pulses = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign line = ~(host_pull | line_pull_o);

    swr_slave #(.LEARN_INIT(LEARN_INIT)) i_swr_slave (
        .clk(clk), .rst_n(rst_n), .line_i(line), .line_pull_o(line_pull_o),
        .flags_i(FLAGS), .tempgg_i(TEMPGG), .chg_lo_i(CHG_LO),
        .chg_hi_o(chg_hi_o), .ident_o(ident_o), .learn_o(learn_o),
        .outctl_o(outctl_o), .full_rst_o(full_rst_o));

    always @(posedge clk) if (full_rst_o) rst_pulses <= rst_pulses + 1;

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic send_bit(input int low);
        host_pull = 1'b1;
        repeat (low) @(negedge clk);
        host_pull = 1'b0;
        repeat (300 - low) @(negedge clk);
    endtask

    task automatic send_break();
        host_pull = 1'b1;
        repeat (350) @(negedge clk);
        host_pull = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i] ? 50 : 180);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit brk);
        if (brk) send_break();
        send_byte({1'b1, a});
        send_byte(d);
        repeat (20) @(negedge clk);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] exp);
        int target;
        target = rx_seen + 1;
        exp_q.push_back(exp);
        send_break();
        send_byte({1'b0, a});
        wait (rx_seen == target);
        repeat (50) @(negedge clk);
    endtask

    task automatic check_regs(input string req, input logic [7:0] ch,
                              input logic [7:0] id, input logic [7:0] le,
                              input logic [7:0] oc);
        check(chg_hi_o == ch, req, chg_hi_o, ch);
        check(ident_o == id, req, ident_o, id);
        check(learn_o == le, req, learn_o, le);
        check(outctl_o == oc, req, outctl_o, oc);
    endtask

    // monitor: decode slave replies and compare with the scoreboard queue
    initial begin
        forever begin
            logic [7:0] got;
            logic [7:0] exp;
            bit tim_ok;
            tim_ok = 1'b1;
            got = '0;
            for (int b = 0; b < 8; b++) begin
                int len;
                len = 0;
                do @(negedge clk); while (!line_pull_o);
                while (line_pull_o) begin
                    len++;
                    @(negedge clk);
                end
                got[b] = (len < 130);
                if (len != (got[b] ? 60 : 200)) tim_ok = 1'b0;
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected pull", got, 8'h00);
            end else begin
                exp = exp_q.pop_front();
                check(got == exp, "R6 read data", got, exp);
                check(tim_ok, "R7 bit timing", {7'b0, tim_ok}, 8'h01);
            end
            rx_seen++;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        check(1'b0, "watchdog", 8'h00, 8'h01);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(line_pull_o == 1'b0, "R1 pull", {7'b0, line_pull_o}, 8'h00);
        check(full_rst_o == 1'b0, "R1 full_rst", {7'b0, full_rst_o}, 8'h00);
        check_regs("R1 regs", 8'h00, 8'h00, LEARN_INIT, 8'h00);

        // R2: no command accepted before the first break
        do_write(7'h04, 8'h77, 1'b0);
        check(ident_o == 8'h00, "R2 no break", ident_o, 8'h00);

        // R3/R4 writes, LSB first
        do_write(7'h04, 8'h5A, 1'b1);
        check(ident_o == 8'h5A, "R4 ident", ident_o, 8'h5A);
        do_write(7'h03, 8'hA5, 1'b1);
        check(chg_hi_o == 8'hA5, "R4 chg_hi", chg_hi_o, 8'hA5);
        do_write(7'h0A, 8'h8F, 1'b1);
        check(outctl_o == 8'h8F, "R4 outctl", outctl_o, 8'h8F);

        // R6 reads
        do_read(7'h01, FLAGS);
        do_read(7'h02, TEMPGG);
        do_read(7'h17, CHG_LO);
        do_read(7'h04, 8'h5A);
        do_read(7'h03, 8'hA5);

        // R5 ignored writes
        do_write(7'h10, 8'hFF, 1'b1);
        do_write(7'h01, 8'hFF, 1'b1);
        check_regs("R5 ignored", 8'hA5, 8'h5A, LEARN_INIT, 8'h8F);
        do_read(7'h0A, 8'h00);

        do_write(7'h05, 8'h33, 1'b1);
        do_read(7'h05, 8'h33);

        // R9 sequence broken by an intervening write
        do_write(7'h05, 8'h00, 1'b1);
        do_write(7'h04, 8'h5A, 1'b1);
        do_write(7'h39, 8'h80, 1'b1);
        check(rst_pulses == 0, "R9 disarmed", 8'(rst_pulses), 8'h00);
        check_regs("R9 disarmed regs", 8'hA5, 8'h5A, 8'h00, 8'h8F);
        // R9 wrong key
        do_write(7'h05, 8'h00, 1'b1);
        do_write(7'h39, 8'h40, 1'b1);
        check(rst_pulses == 0, "R9 bad key", 8'(rst_pulses), 8'h00);
        check_regs("R9 bad key regs", 8'hA5, 8'h5A, 8'h00, 8'h8F);

        // R8 full reset
        do_write(7'h05, 8'h00, 1'b1);
        do_write(7'h39, 8'h80, 1'b1);
        check(rst_pulses == 1, "R8 pulse", 8'(rst_pulses), 8'h01);
        check_regs("R8 regs", 8'h00, 8'h5A, LEARN_INIT, 8'h00);

        // R10 break on final data frame of a write aborts it
        send_break();
        send_byte(8'h84);
        for (int i = 0; i < 7; i++) send_bit(8'h11 >> i & 1 ? 50 : 180);
        host_pull = 1'b1;
        repeat (350) @(negedge clk);
        host_pull = 1'b0;
        repeat (150) @(negedge clk);
        check(ident_o == 8'h5A, "R10 aborted write", ident_o, 8'h5A);
        do_write(7'h04, 8'h22, 1'b0);
        check(ident_o == 8'h22, "R10 resume", ident_o, 8'h22);
        check(exp_q.size() == 0, "R7 queue drained", 8'(exp_q.size()), 8'h00);

        finish_run();
    end
endmodule